// File: doc/BRIEF.md
# System Configuration Register Unit

This block holds one 16-bit configuration word for a chip's system integration logic. Software reads and writes it through a plain strobe interface. Its fields drive control outputs for other units:

- the output enable of the clock output pin;
- freeze-time gating of the enables for the watchdog, the periodic timer and the bus monitor;
- the decoded show-cycle mode for the external bus interface;
- the interrupt arbitration priority value;
- the address bit that places the internal module window in the 24-bit address space.

The unit decodes each incoming address against that window and raises a hit flag. A read-only status bit is captured from data bus bit 11 while reset is held. The mapping bit takes only the first write after reset. The timers, the bus monitor and the external bus interface sit outside the block.

Reset is asynchronous and active low. Inside the block it is released through a two-stage synchronizer, so the register leaves reset on the second rising clock edge after `rst_n` rises.

Top module: `cfg_reg_unit`

## Requirements
- R1: After reset the word reads 0x00CF with bit 11 equal to the captured status. The fields are: clock-off 0, freeze-software 0, freeze-monitor 0, show mode 00, supervisor bit 1, mapping bit 1, arbitration 1111.
- R2: The layout is:
  - bit 15: clock-off;
  - bit 14: freeze-software;
  - bit 13: freeze-monitor;
  - bit 11: status, read-only;
  - bits 9:8: show mode;
  - bit 7: supervisor;
  - bit 6: mapping;
  - bits 3:0: arbitration.

  A `wr_en` cycle loads every writable field from `wdata`. Bits 12, 10, 5 and 4 always read 0. `rdata` is 0 whenever `rd_en` is low.
- R3: While `freeze` is high and freeze-software is 1, `wdog_en` and `pit_en` are 0. In every other case they follow `wdog_req` and `pit_req`.
- R4: While `freeze` is high and freeze-monitor is 1, `bmon_en` is 0. Otherwise it follows `bmon_req`.
- R5: The status bit takes the value of `wdata[11]` sampled while reset is held. Later writes do not change it.
- R6: The first write after reset sets the mapping bit. Later writes leave it unchanged while still updating the other fields. Only reset restores the ability to write it.
- R7: The show mode decodes as follows (`show_en`, `ext_arb_en`):
  - 00: 0, 1;
  - 01: 1, 0;
  - 10: 1, 1;
  - 11: 1, 1.

  `halt_int` is 1 only when the mode is 11 and `bus_grant` is high.
- R8: `mod_hit` is 1 when `addr[22:12]` is all ones and `addr[23]` equals the mapping bit. Mapping 1 gives the window 0xFFF000–0xFFFFFF, and mapping 0 gives 0x7FF000–0x7FFFFF.
- R9: `clkout_oe` is the inverse of the clock-off bit.
- R10: The supervisor bit is stored and read back but changes no output.
- R11: `arb_id` equals the arbitration field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data; bit 11 is also sampled during reset |
| rdata | output | 16 | Read data, zero when not reading |
| freeze | input | 1 | Debug freeze |
| bus_grant | input | 1 | External bus grant active |
| wdog_req | input | 1 | Watchdog run request |
| pit_req | input | 1 | Periodic timer run request |
| bmon_req | input | 1 | Bus monitor run request |
| addr | input | 24 | Address to decode |
| clkout_oe | output | 1 | Clock output pin enable |
| wdog_en | output | 1 | Gated watchdog enable |
| pit_en | output | 1 | Gated periodic timer enable |
| bmon_en | output | 1 | Gated bus monitor enable |
| show_en | output | 1 | Show cycles enabled |
| ext_arb_en | output | 1 | External arbitration allowed |
| halt_int | output | 1 | Halt internal activity |
| arb_id | output | 4 | Interrupt arbitration value |
| mod_hit | output | 1 | Address falls in internal module window |

## Verification
The hardest state to reach is a mapping bit of 0. Reset sets it to 1, and after the first write it can no longer change. The stimulus applies a fresh reset and makes its first write one that clears the bit. It then checks that the window has moved to the lower range and that a later attempt to set the bit again has no effect. The status bit is also hard to control, because only the bus value during reset sets it. Two resets with opposite values on `wdata[11]` cover both states.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_DW = 16;

  localparam int B_CLKOFF = 15;
  localparam int B_FRZSW  = 14;
  localparam int B_FRZBM  = 13;
  localparam int B_SLV    = 11;
  localparam int B_SHOW   = 8;
  localparam int B_SUPV   = 7;
  localparam int B_MAP    = 6;
  localparam int B_ARB    = 0;
  localparam int ARB_W    = 4;

  typedef enum logic [1:0] {
    SHOW_OFF   = 2'b00,
    SHOW_NOARB = 2'b01,
    SHOW_ARB   = 2'b10,
    SHOW_HALT  = 2'b11
  } show_mode_e;

  typedef struct packed {
    logic             clk_off;
    logic             frz_sw;
    logic             frz_bm;
    show_mode_e       show;
    logic             supv;
    logic             map;
    logic [ARB_W-1:0] arb;
  } cfg_fields_t;

  localparam cfg_fields_t CFG_RST = '{
    clk_off: 1'b0, frz_sw: 1'b0, frz_bm: 1'b0, show: SHOW_OFF,
    supv: 1'b1, map: 1'b1, arb: '1};
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter int DW = CFG_DW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [DW-1:0] wdata,
  output cfg_fields_t cfg_q,
  output logic        map_locked,
  output logic        slv_q
);
  cfg_fields_t cfg_d;
  logic        lock_d;
  logic        slv_d;
  logic        unused_wbits;

  assign unused_wbits = ^{wdata[12], wdata[10], wdata[5:4], wdata[DW-1:16]};

  // next state: all fields follow a write, mapping bit only while unlocked
  always_comb begin
    cfg_d  = cfg_q;
    lock_d = map_locked;
    if (wr_en) begin
      cfg_d.clk_off = wdata[B_CLKOFF];
      cfg_d.frz_sw  = wdata[B_FRZSW];
      cfg_d.frz_bm  = wdata[B_FRZBM];
      cfg_d.show    = show_mode_e'(wdata[B_SHOW +: 2]);
      cfg_d.supv    = wdata[B_SUPV];
      cfg_d.arb     = wdata[B_ARB +: ARB_W];
      if (!map_locked) cfg_d.map = wdata[B_MAP];
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RST;
      map_locked <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      map_locked <= lock_d;
    end
  end

  // status bit: sampled from the bus every clock while reset is held
  always_comb begin
    slv_d = rst_n ? slv_q : wdata[B_SLV];
  end

  always_ff @(posedge clk) begin
    slv_q <= slv_d;
  end
endmodule

// File: rtl/cfg_ctrl_decode.sv
module cfg_ctrl_decode
  import cfg_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BLK_LSB = 12
) (
  input  cfg_fields_t        cfg_q,
  input  logic               freeze,
  input  logic               bus_grant,
  input  logic               wdog_req,
  input  logic               pit_req,
  input  logic               bmon_req,
  input  logic [AW-1:BLK_LSB] addr_hi,
  output logic               clkout_oe,
  output logic               wdog_en,
  output logic               pit_en,
  output logic               bmon_en,
  output logic               show_en,
  output logic               ext_arb_en,
  output logic               halt_int,
  output logic               mod_hit
);
  localparam int WIN_W = AW - 1 - BLK_LSB;

  logic sw_hold;
  logic bm_hold;

  always_comb begin
    sw_hold   = freeze & cfg_q.frz_sw;
    bm_hold   = freeze & cfg_q.frz_bm;
    clkout_oe = ~cfg_q.clk_off;
    wdog_en   = wdog_req & ~sw_hold;
    pit_en    = pit_req  & ~sw_hold;
    bmon_en   = bmon_req & ~bm_hold;
  end

  always_comb begin
    show_en    = 1'b1;
    ext_arb_en = 1'b1;
    halt_int   = 1'b0;
    unique case (cfg_q.show)
      SHOW_OFF:   show_en    = 1'b0;
      SHOW_NOARB: ext_arb_en = 1'b0;
      SHOW_ARB:   ;
      SHOW_HALT:  halt_int   = bus_grant;
      default:    ;
    endcase
  end

  always_comb begin
    mod_hit = (&addr_hi[AW-2 -: WIN_W]) & (addr_hi[AW-1] == cfg_q.map);
  end
endmodule

// File: rtl/cfg_reg_unit.sv
module cfg_reg_unit
  import cfg_pkg::*;
#(
  parameter int DW      = CFG_DW,
  parameter int AW      = 24,
  parameter int BLK_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          freeze,
  input  logic          bus_grant,
  input  logic          wdog_req,
  input  logic          pit_req,
  input  logic          bmon_req,
  input  logic [AW-1:0] addr,
  output logic          clkout_oe,
  output logic          wdog_en,
  output logic          pit_en,
  output logic          bmon_en,
  output logic          show_en,
  output logic          ext_arb_en,
  output logic          halt_int,
  output logic [ARB_W-1:0] arb_id,
  output logic          mod_hit
);
  logic        rst_int_n;
  cfg_fields_t cfg_q;
  logic        map_locked;
  logic        slv_q;
  logic [DW-1:0] word;
  logic        unused_addr;

  assign unused_addr = ^addr[BLK_LSB-1:0];

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cfg_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wdata(wdata),
    .cfg_q(cfg_q), .map_locked(map_locked), .slv_q(slv_q)
  );

  cfg_ctrl_decode #(.AW(AW), .BLK_LSB(BLK_LSB)) u_dec (
    .cfg_q(cfg_q), .freeze(freeze), .bus_grant(bus_grant),
    .wdog_req(wdog_req), .pit_req(pit_req), .bmon_req(bmon_req),
    .addr_hi(addr[AW-1:BLK_LSB]),
    .clkout_oe(clkout_oe), .wdog_en(wdog_en), .pit_en(pit_en),
    .bmon_en(bmon_en), .show_en(show_en), .ext_arb_en(ext_arb_en),
    .halt_int(halt_int), .mod_hit(mod_hit)
  );

  always_comb begin
    word = '0;
    word[B_CLKOFF]        = cfg_q.clk_off;
    word[B_FRZSW]         = cfg_q.frz_sw;
    word[B_FRZBM]         = cfg_q.frz_bm;
    word[B_SLV]           = slv_q;
    word[B_SHOW +: 2]     = cfg_q.show;
    word[B_SUPV]          = cfg_q.supv;
    word[B_MAP]           = cfg_q.map;
    word[B_ARB +: ARB_W]  = cfg_q.arb;
    rdata  = rd_en ? word : '0;
    arb_id = cfg_q.arb;
  end
endmodule

// File: rtl/cfg_reg_unit_chk.sv
module cfg_reg_unit_chk
  import cfg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] rdata,
  input logic        freeze,
  input logic        bus_grant,
  input logic        map_locked,
  input cfg_fields_t cfg_q,
  input logic        slv_q,
  input logic        wdog_en,
  input logic        pit_en,
  input logic        bmon_en,
  input logic        show_en,
  input logic        ext_arb_en,
  input logic        halt_int,
  input logic        clkout_oe
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[12] == 1'b0) && (rdata[10] == 1'b0) && (rdata[5:4] == 2'b00)) else $error("rsvd"); // R2
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 16'h0) else $error("idle read"); // R2
  AST_SW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && cfg_q.frz_sw) |-> (!wdog_en && !pit_en)) else $error("sw freeze"); // R3
  AST_BM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && cfg_q.frz_bm) |-> !bmon_en) else $error("bm freeze"); // R4
  AST_SLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(slv_q)) else $error("slv"); // R5
  AST_MAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (map_locked && wr_en) |=> $stable(cfg_q.map)) else $error("map"); // R6
  AST_SHOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.show == SHOW_OFF) |-> (!show_en && ext_arb_en)) else $error("show"); // R7
  AST_HALT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    halt_int |-> (bus_grant && cfg_q.show == SHOW_HALT)) else $error("halt"); // R7
  AST_CLK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.clk_off |-> !clkout_oe) else $error("clk"); // R9
endmodule

bind cfg_reg_unit cfg_reg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .freeze(freeze), .bus_grant(bus_grant), .map_locked(map_locked),
  .cfg_q(cfg_q), .slv_q(slv_q), .wdog_en(wdog_en), .pit_en(pit_en),
  .bmon_en(bmon_en), .show_en(show_en), .ext_arb_en(ext_arb_en),
  .halt_int(halt_int), .clkout_oe(clkout_oe)
);

// File: tb/sim_cfg_reg_unit.sv
`timescale 1ns/1ps
module sim_cfg_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [15:0] wdata, rdata;
  logic        freeze, bus_grant, wdog_req, pit_req, bmon_req;
  logic [23:0] addr;
  logic        clkout_oe, wdog_en, pit_en, bmon_en, show_en, ext_arb_en, halt_int, mod_hit;
  logic [3:0]  arb_id;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic slv_exp;

  always #2.5 clk = ~clk;

  cfg_reg_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .freeze(freeze), .bus_grant(bus_grant), .wdog_req(wdog_req),
    .pit_req(pit_req), .bmon_req(bmon_req), .addr(addr), .clkout_oe(clkout_oe),
    .wdog_en(wdog_en), .pit_en(pit_en), .bmon_en(bmon_en), .show_en(show_en),
    .ext_arb_en(ext_arb_en), .halt_int(halt_int), .arb_id(arb_id), .mod_hit(mod_hit)
  );

  // {wdata, freeze, grant, expected {oe, wdog, pit, bmon, show, arb, halt}}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {16'h00CF, 1'b0, 1'b0, 7'b1111010},
    {16'h40C5, 1'b1, 1'b0, 7'b1001010},
    {16'h20C3, 1'b1, 1'b0, 7'b1110010},
    {16'h60C1, 1'b0, 1'b0, 7'b1111010},
    {16'h8140, 1'b0, 1'b1, 7'b0111100},
    {16'h02C8, 1'b0, 1'b1, 7'b1111110},
    {16'h03CA, 1'b0, 1'b0, 7'b1111110},
    {16'h03CA, 1'b0, 1'b1, 7'b1111111},
    {16'h6340, 1'b1, 1'b1, 7'b1000111},
    {16'hFFFF, 1'b0, 1'b0, 7'b0111110}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {clkout_oe, wdog_en, pit_en, bmon_en, show_en, ext_arb_en, halt_int};
  endfunction

  task automatic do_reset(input logic s11);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 16'h0; wdata[11] = s11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    slv_exp = s11;
  endtask

  task automatic write(input logic [15:0] d);
    wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read(output logic [15:0] d);
    rd_en = 1'b1; #1; d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [6:0]  o_a;
    rst_n = 1'b1; wr_en = 0; rd_en = 0; wdata = 0; freeze = 0; bus_grant = 0;
    wdog_req = 1; pit_req = 1; bmon_req = 1; addr = 24'h0;

    do_reset(1'b1);
    read(rd);
    check("R1 R5 reset word", rd, 32'h08CF);
    check("R11 reset arb", arb_id, 4'hF);
    #1 check("R2 idle rdata", rdata, 16'h0);

    for (int i = 0; i < NV; i++) begin
      freeze = VEC[i][8]; bus_grant = VEC[i][7];
      write(VEC[i][24:9]);
      #1;
      check("R3 R4 R7 R9 outputs", outs(), VEC[i][6:0]);
      check("R11 arb", arb_id, VEC[i][12:9]);
      read(rd);
      check("R2 R5 readback", rd,
            (VEC[i][24:9] & 16'hE38F) | 16'h0040 | {4'h0, slv_exp, 11'h0});
    end
    freeze = 0; bus_grant = 0;

    // R3 R4: requests low stay low regardless of freeze
    wdog_req = 0; pit_req = 0; bmon_req = 0; #1;
    check("R3 R4 request low", {wdog_en, pit_en, bmon_en}, 3'b000);
    wdog_req = 1; pit_req = 1; bmon_req = 1;

    // R10: supervisor bit has no output effect
    write(16'h0047); #1; o_a = outs();
    write(16'h00C7); #1;
    check("R10 supv outputs", outs(), o_a);
    read(rd);
    check("R10 supv readback", rd[7], 1'b1);

    // R6: locked mapping bit ignores a clear, other fields still written
    write(16'h0005);
    read(rd);
    check("R6 map locked", rd, 16'h0845);
    addr = 24'hFFF123; #1; check("R8 hi window", mod_hit, 1'b1);
    addr = 24'h7FF123; #1; check("R8 lo miss", mod_hit, 1'b0);
    addr = 24'hFFE000; #1; check("R8 below window", mod_hit, 1'b0);

    // R5 R6 R8: fresh reset with status 0, first write clears mapping
    do_reset(1'b0);
    read(rd);
    check("R1 R5 reset word", rd, 32'h00CF);
    write(16'h080F);
    read(rd);
    check("R5 R6 first write", rd, 16'h000F);
    addr = 24'h7FF000; #1; check("R8 lo window", mod_hit, 1'b1);
    addr = 24'hFFF000; #1; check("R8 hi miss", mod_hit, 1'b0);
    write(16'h004A);
    read(rd);
    check("R6 relock", rd, 16'h000A);
    addr = 24'h7FFFFF; #1; check("R8 lo top", mod_hit, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule